// File: doc/BRIEF.md
# Sequential GF(2) Polynomial Divider

This unit divides one WIDTH-bit unsigned operand by another, treating both as polynomials with coefficients in GF(2). Subtraction becomes XOR and no carries propagate. A single start strobe hands over the dividend and the divisor. The unit then reports busy, produces one quotient bit per clock, and ends with a one-cycle done pulse. At that point the registered quotient and remainder are valid.

Before iterating, the divisor is left-aligned so that its top bit is set. The alignment amount is the leading-zero count of the divisor with its lowest bit dropped, so it never exceeds WIDTH-1 and fits in a ceil-log2 sized register. The dividend is moved left by the same amount into a double-width working register. After WIDTH conditional XOR steps, the upper half of that register is moved back right by the alignment amount to give the remainder. A zero divisor skips the iterations entirely and is flagged.

Top module: `clx_divider`

## Requirements
- R1: For any nonzero divisor d and any dividend n, the results satisfy n = clmul(quotient, d) XOR remainder, and the remainder has a lower polynomial degree than d.
- R2: For a nonzero divisor, done_o pulses for exactly one cycle. The operation spans WIDTH+2 clock cycles, counting the cycle in which start_i is sampled. busy_o is high from the cycle after the accepting edge until done_o rises.
- R3: The alignment amount is at most WIDTH-1, and the aligned divisor always has its top bit set. For d = 2^k, the quotient is n >> k and the remainder is the low k bits of n. When d = 1, the quotient is n and the remainder is 0.
- R4: With a zero divisor, done_o and dbz_o are high in the cycle right after the accepting edge. In that case quot_o is 0 and rem_o equals the dividend.
- R5: A start_i pulse while busy_o is high is ignored. The running operation finishes with its own operands and keeps its latency.
- R6: While idle and without start_i, quot_o, rem_o and dbz_o hold their values. dbz_o clears when a start with a nonzero divisor is accepted.
- R7: After reset, busy_o, done_o, dbz_o, quot_o and rem_o are all 0.
- R8: busy_o and done_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| dividend_i | input | WIDTH | Dividend polynomial, sampled with start_i |
| divisor_i | input | WIDTH | Divisor polynomial, sampled with start_i |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| dbz_o | output | 1 | Last accepted divisor was zero |
| quot_o | output | WIDTH | Registered quotient |
| rem_o | output | WIDTH | Registered remainder |

## Verification
The bench builds the unit with WIDTH = 8. At this width every alignment amount from 0 to 7 can be reached by sweeping the divisor over single-bit powers, and the d = 1 case drives the amount to its cap. An 8-bit width also lets a few hundred random operand pairs cover many different divisor degrees within a short run. A bench-side long division and a carry-less product give expected values that do not depend on the alignment trick.

// File: rtl/clx_div_pkg.sv
package clx_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIN  = 2'd2
    } clx_state_e;
endpackage

// File: rtl/clx_lzc.sv
module clx_lzc #(
    parameter int IN_W  = 7,
    parameter int CNT_W = 3
) (
    input  logic [IN_W-1:0]  vec_i,
    output logic [CNT_W-1:0] count_o
);
    logic seen;

    // Count zeros from the top; an all-zero vector yields IN_W.
    always_comb begin
        count_o = CNT_W'(IN_W);
        seen    = 1'b0;
        for (int i = IN_W - 1; i >= 0; i--) begin
            if (!seen && vec_i[i]) begin
                count_o = CNT_W'(IN_W - 1 - i);
                seen    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/clx_div_step.sv
module clx_div_step #(
    parameter int WIDTH = 8
) (
    input  logic [2*WIDTH-1:0] rem_i,
    input  logic [WIDTH-1:0]   quo_i,
    input  logic [WIDTH-1:0]   dnorm_i,
    output logic [2*WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0]   quo_o
);
    localparam int RW = 2 * WIDTH;

    logic [RW-1:0] shifted;
    logic          hit;

    always_comb begin
        shifted = rem_i << 1;
        hit     = shifted[RW-1];
        rem_o   = hit ? (shifted ^ {dnorm_i, {WIDTH{1'b0}}}) : shifted;
        quo_o   = {quo_i[WIDTH-2:0], hit};
    end
endmodule

// File: rtl/clx_divider.sv
module clx_divider #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             dbz_o,
    output logic [WIDTH-1:0] quot_o,
    output logic [WIDTH-1:0] rem_o
);
    import clx_div_pkg::*;

    localparam int SHW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam int RW  = 2 * WIDTH;
    localparam int CW  = $clog2(WIDTH + 1);

    typedef struct packed {
        clx_state_e       st;
        logic [RW-1:0]    work;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] dnorm;
        logic [WIDTH-1:0] dorig;
        logic [SHW-1:0]   sh;
        logic [CW-1:0]    cnt;
        logic             busy;
        logic             done;
        logic             dbz;
        logic [WIDTH-1:0] q_out;
        logic [WIDTH-1:0] r_out;
    } regs_t;

    regs_t r_q, r_d;

    logic [SHW-1:0]   lz_d;
    logic [RW-1:0]    step_work_d;
    logic [WIDTH-1:0] step_quo_d;

    clx_lzc #(.IN_W(WIDTH - 1), .CNT_W(SHW)) u_lzc (
        .vec_i   (divisor_i[WIDTH-1:1]),
        .count_o (lz_d)
    );

    clx_div_step #(.WIDTH(WIDTH)) u_step (
        .rem_i   (r_q.work),
        .quo_i   (r_q.quo),
        .dnorm_i (r_q.dnorm),
        .rem_o   (step_work_d),
        .quo_o   (step_quo_d)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.dorig = divisor_i;
                    r_d.dbz   = 1'b0;
                    if (divisor_i == '0) begin
                        r_d.dbz   = 1'b1;
                        r_d.done  = 1'b1;
                        r_d.q_out = '0;
                        r_d.r_out = dividend_i;
                    end else begin
                        r_d.busy  = 1'b1;
                        r_d.st    = ST_ITER;
                        r_d.sh    = lz_d;
                        r_d.dnorm = divisor_i << lz_d;
                        r_d.work  = RW'(dividend_i) << lz_d;
                        r_d.quo   = '0;
                        r_d.cnt   = '0;
                    end
                end
            end
            ST_ITER: begin
                r_d.work = step_work_d;
                r_d.quo  = step_quo_d;
                r_d.cnt  = r_q.cnt + CW'(1);
                if (r_q.cnt == CW'(WIDTH - 1)) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.busy  = 1'b0;
                r_d.done  = 1'b1;
                r_d.st    = ST_IDLE;
                r_d.q_out = r_q.quo;
                r_d.r_out = WIDTH'((r_q.work >> WIDTH) >> r_q.sh);
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = r_q.busy;
    assign done_o = r_q.done;
    assign dbz_o  = r_q.dbz;
    assign quot_o = r_q.q_out;
    assign rem_o  = r_q.r_out;

    // R3: the alignment amount stays within WIDTH-1
    p_shift_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(r_q.sh) <= WIDTH - 1));

    // R3: the aligned divisor has its top bit set while iterating
    p_norm_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ITER) |-> r_q.dnorm[WIDTH-1]);

    // R8
    p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R6
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(quot_o) && $stable(rem_o) && $stable(dbz_o)));

    // R4
    p_dbz_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dbz_o) |-> (quot_o == '0));

    // R1: remainder degree below divisor degree
    p_rem_degree_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dbz_o) |-> ((rem_o < r_q.dorig) && ((rem_o ^ r_q.dorig) > rem_o)));

    // R5: a running division carries on regardless of start_i
    p_keep_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    // R2
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);
endmodule

// File: tb/clx_divider_tb_top.sv
module clx_divider_tb_top;
    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] n_in = '0;
    logic [W-1:0] d_in = '0;
    logic         busy, done, dbz;
    logic [W-1:0] quot, rem;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clx_divider #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dividend_i(n_in), .divisor_i(d_in),
        .busy_o(busy), .done_o(done), .dbz_o(dbz),
        .quot_o(quot), .rem_o(rem)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int deg(input logic [W-1:0] x);
        int r = -1;
        for (int i = 0; i < W; i++) if (x[i]) r = i;
        return r;
    endfunction

    function automatic logic [2*W-1:0] clmul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] p = '0;
        for (int i = 0; i < W; i++) if (b[i]) p ^= ({{W{1'b0}}, a} << i);
        return p;
    endfunction

    task automatic ref_div(input logic [W-1:0] n, input logic [W-1:0] d,
                           output logic [W-1:0] q, output logic [W-1:0] r);
        int dg = deg(d);
        r = n;
        q = '0;
        for (int i = W - 1; i >= dg; i--) begin
            if (r[i]) begin
                r ^= d << (i - dg);
                q[i - dg] = 1'b1;
            end
        end
    endtask

    // Issues one start and waits for done; samples at negedges.
    task automatic run_op(input logic [W-1:0] n, input logic [W-1:0] d,
                          output int cyc, output bit overlap, output bit busy_early);
        @(negedge clk);
        start = 1'b1; n_in = n; d_in = d;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        busy_early = busy;
        overlap = busy && done;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (busy && done) overlap = 1'b1;
        end
    endtask

    task automatic t_reset;
        chk("R7 busy after reset", 32'(busy), 0);
        chk("R7 done after reset", 32'(done), 0);
        chk("R7 dbz after reset", 32'(dbz), 0);
        chk("R7 quot after reset", 32'(quot), 0);
        chk("R7 rem after reset", 32'(rem), 0);
    endtask

    task automatic t_basic;
        logic [W-1:0] eq, er;
        int cyc; bit ov, be;
        run_op(8'hC3, 8'h0B, cyc, ov, be);
        ref_div(8'hC3, 8'h0B, eq, er);
        chk("R1 basic quotient", 32'(quot), 32'(eq));
        chk("R1 basic remainder", 32'(rem), 32'(er));
        chk("R2 latency", 32'(cyc), 32'(W + 2));
        chk("R2 busy after accept", 32'(be), 1);
        chk("R8 busy/done overlap", 32'(ov), 0);
        @(negedge clk);
        chk("R2 done single pulse", 32'(done), 0);
    endtask

    task automatic t_shift_sweep;
        int cyc; bit ov, be;
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] d = W'(1) << k;
            run_op(8'hA7, d, cyc, ov, be);
            chk("R3 power-of-two quotient", 32'(quot), 32'(8'hA7 >> k));
            chk("R3 power-of-two remainder", 32'(rem), 32'(8'hA7 & ((1 << k) - 1)));
            chk("R2 latency per shift", 32'(cyc), 32'(W + 2));
        end
    endtask

    task automatic t_dbz;
        int cyc; bit ov, be;
        run_op(8'h5A, 8'h00, cyc, ov, be);
        chk("R4 zero divisor latency", 32'(cyc), 1);
        chk("R4 zero divisor flag", 32'(dbz), 1);
        chk("R4 zero divisor quotient", 32'(quot), 0);
        chk("R4 zero divisor remainder", 32'(rem), 32'(8'h5A));
        run_op(8'h00, 8'h13, cyc, ov, be);
        chk("R6 flag cleared by next start", 32'(dbz), 0);
        chk("R1 zero dividend quotient", 32'(quot), 0);
        chk("R1 zero dividend remainder", 32'(rem), 0);
    endtask

    task automatic t_busy_ignore;
        logic [W-1:0] eq, er;
        int cyc = 1;
        ref_div(8'hF1, 8'h1D, eq, er);
        @(negedge clk);
        start = 1'b1; n_in = 8'hF1; d_in = 8'h1D;
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin @(negedge clk); cyc++; end
        start = 1'b1; n_in = 8'h3C; d_in = 8'h00;
        @(negedge clk); cyc++;
        start = 1'b0;
        while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
        chk("R5 ignored start quotient", 32'(quot), 32'(eq));
        chk("R5 ignored start remainder", 32'(rem), 32'(er));
        chk("R5 ignored start flag", 32'(dbz), 0);
        chk("R5 latency unchanged", 32'(cyc), 32'(W + 2));
    endtask

    task automatic t_hold;
        logic [W-1:0] q0, r0;
        q0 = quot; r0 = rem;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            n_in = W'(i * 37); d_in = W'(i);
        end
        chk("R6 quotient held", 32'(quot), 32'(q0));
        chk("R6 remainder held", 32'(rem), 32'(r0));
        chk("R6 idle not busy", 32'(busy), 0);
        chk("R6 no spurious done", 32'(done), 0);
    endtask

    task automatic t_random;
        int bad = 0;
        int cyc; bit ov, be;
        for (int i = 0; i < 250; i++) begin
            logic [W-1:0] n = W'($urandom);
            logic [W-1:0] d = W'($urandom);
            if (d == '0) d = 8'h01;
            run_op(n, d, cyc, ov, be);
            if ((clmul(quot, d) ^ {{W{1'b0}}, rem}) !== {{W{1'b0}}, n}) begin
                bad++;
                chk("R1 random identity", 32'(clmul(quot, d) ^ {{W{1'b0}}, rem}), 32'(n));
            end
            if (deg(rem) >= deg(d)) begin
                bad++;
                chk("R1 random remainder degree", 32'(deg(rem)), 32'(deg(d) - 1));
            end
        end
        chk("R1 random mismatches", 32'(bad), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_shift_sweep();
        t_dbz();
        t_busy_ignore();
        t_hold();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule